// File: doc/BRIEF.md
# Clock Frequency Limit Monitor

This block watches a single reference clock and grades it, once per measurement window, as valid, flagged-but-usable or invalid. The reference is brought into the local system-clock domain through a flop synchroniser and a rising-edge detector. The detected edges are counted over a programmable gate window of system-clock cycles. At the end of each window, the count is compared with two inclusive count windows. The wide one is the hard limit: a count outside it disqualifies the reference. The narrow one is the soft limit: a count inside the hard limit but outside the soft limit raises an alarm, and the reference stays usable.

Alongside the frequency check, an idle timer tracks how many consecutive system-clock cycles have passed without a reference edge. If that number reaches a programmable limit anywhere inside a window, the window ends with activity loss. Each check has its own enable, so software can run the activity check, the frequency check, both, or neither. All status outputs are registered and move only at window boundaries. A reference that recovers is therefore graded usable only after one complete window in which it behaved.

Top module: `freq_limit_monitor`

## Requirements
- R1: Every rising edge of `ref_clk_i` adds exactly one to the count of the window in which it is detected. A strictly periodic reference of period P system-clock cycles, measured over a window of N cycles with P dividing N, reports exactly N/P.
- R2: A window lasts `cfg_gate_len` system-clock cycles, and a value of 0 acts as 1. In the cycle after a window closes, `meas_valid_o` is high for one cycle and `meas_count_o` holds that window's edge count. When the window length is 0 or 1, `meas_valid_o` is high in every cycle.
- R3: When the frequency check is enabled and the count is below `cfg_hard_lo` or above `cfg_hard_hi`, `hard_fail_o` goes to 1, `grade_o` goes to 2 (invalid) and `ref_usable_o` goes to 0.
- R4: When the frequency check is enabled and the count is inside the hard limit but below `cfg_soft_lo` or above `cfg_soft_hi`, `soft_alarm_o` goes to 1 and `grade_o` goes to 1 (flagged). `ref_usable_o` stays 1 in this case.
- R5: All four limits are inclusive. A count equal to a limit value is inside that limit, and a count one beyond a hard limit is outside it.
- R6: When the activity check is enabled, `act_lost_o` is set at the end of any window that contains a run of at least `cfg_idle_limit` consecutive system-clock cycles with no detected edge. A reference of period P triggers activity loss when the idle limit is P-1 or lower, and does not trigger it when the idle limit is P.
- R7: When `cfg_freq_en` is 0, `hard_fail_o` and `soft_alarm_o` read 0 after each window. When `cfg_act_en` is 0, `act_lost_o` reads 0 after each window.
- R8: The status outputs hold their values between window ends. An invalid grade caused by a disturbed window clears after the first following window that is entirely in limit.
- R9: During and right after reset, the outputs are as follows: `grade_o` is 2, `act_lost_o` is 1, `ref_usable_o` is 0, and `hard_fail_o`, `soft_alarm_o`, `meas_valid_o` and `meas_count_o` are 0.
- R10: The grade encoding is 0 for valid, 1 for flagged and 2 for invalid, and code 3 never appears. Either activity loss or a hard-limit violation makes the grade invalid. Invalid takes precedence over flagged. `ref_usable_o` is 1 exactly when the grade is not invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the measurement time base |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Monitored reference clock, asynchronous to clk |
| cfg_act_en | input | 1 | Enables the activity check |
| cfg_freq_en | input | 1 | Enables the frequency limit checks |
| cfg_gate_len | input | GATE_W | Window length in system-clock cycles (0 acts as 1) |
| cfg_idle_limit | input | IDLE_W | Edge-free run, in cycles, that counts as activity loss |
| cfg_hard_lo | input | CNT_W | Lowest edge count inside the hard limit |
| cfg_hard_hi | input | CNT_W | Highest edge count inside the hard limit |
| cfg_soft_lo | input | CNT_W | Lowest edge count inside the soft limit |
| cfg_soft_hi | input | CNT_W | Highest edge count inside the soft limit |
| meas_count_o | output | CNT_W | Edge count of the last completed window |
| meas_valid_o | output | 1 | One-cycle strobe marking a new window result |
| act_lost_o | output | 1 | Activity loss seen in the last window |
| hard_fail_o | output | 1 | Count outside the hard limit |
| soft_alarm_o | output | 1 | Count inside the hard limit but outside the soft limit |
| grade_o | output | 2 | 0 valid, 1 flagged, 2 invalid |
| ref_usable_o | output | 1 | Reference is valid or only flagged |

## Verification
The assertions assume that the reference toggles no faster than half the system-clock rate, so that the synchroniser sees every level. They do not assume that configuration changes line up with window boundaries. Their checks on the check enables use the enable values sampled at the edge that closed the window. The stimulus drives the reference and every configuration input only on falling clock edges. The reference period is held at two or more system cycles and always divides the gate length. After each configuration change, the two windows that may straddle the change are discarded before the result is compared.

// File: rtl/fm_pkg.sv
// Package fm_pkg
// Shared grade encoding and the inclusive range test used by the limit
// monitor. Assumes limits are given as lowest and highest accepted counts.
package fm_pkg;

    typedef enum logic [1:0] {
        GRADE_VALID   = 2'd0,
        GRADE_FLAGGED = 2'd1,
        GRADE_INVALID = 2'd2
    } grade_e;

    // Inclusive window test on an unsigned count of up to 32 bits.
    function automatic logic outside_range(input logic [31:0] value,
                                           input logic [31:0] lo,
                                           input logic [31:0] hi);
        return (value < lo) || (value > hi);
    endfunction

endpackage

// File: rtl/fm_edge_sync.sv
// Module fm_edge_sync
// Brings an asynchronous reference clock into the system domain through a
// chain of SYNC_STAGES flops and flags each rising edge for one cycle.
// Assumes the reference stays at each level for at least one system cycle.
module fm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Stage 0 captures the raw asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end

    // Remaining stages settle any metastable value.
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    // Rising edge: new level high, previous level low.
    always_comb rise_o = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/fm_gate_timer.sv
// Module fm_gate_timer
// Times the measurement window and accumulates detected edges inside it.
// win_count_o is the saturating count including the current cycle's edge
// and is meaningful in the cycle win_end_o is high. A length of 0 acts as 1.
module fm_gate_timer #(
    parameter int GATE_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic [GATE_W-1:0] gate_len_i,
    output logic              win_end_o,
    output logic [CNT_W-1:0]  win_count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [GATE_W-1:0] gate_q;
    logic [CNT_W-1:0]  acc_q;
    logic [CNT_W-1:0]  sum;
    logic              last;

    // Window closes at the programmed length or beyond it after a shrink.
    always_comb begin
        last = (gate_len_i == '0) || (gate_q >= gate_len_i - GATE_W'(1));
    end

    // Saturating edge sum including this cycle.
    always_comb begin
        if (acc_q == CNT_MAX) sum = CNT_MAX;
        else                  sum = acc_q + CNT_W'(rise_i);
    end

    // Cycle position inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)    gate_q <= '0;
        else if (last) gate_q <= '0;
        else           gate_q <= gate_q + GATE_W'(1);
    end

    // Edge accumulator, restarted at each window close.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (last) acc_q <= '0;
        else           acc_q <= sum;
    end

    assign win_end_o   = last;
    assign win_count_o = sum;

endmodule

// File: rtl/fm_idle_watch.sv
// Module fm_idle_watch
// Counts consecutive system cycles without a detected edge and remembers,
// per window, whether that run ever reached the programmed limit.
// starved_o includes the current cycle and is sampled at the window close.
module fm_idle_watch #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              win_end_i,
    input  logic [IDLE_W-1:0] idle_limit_i,
    output logic              starved_o
);
    localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

    logic [IDLE_W-1:0] idle_q;
    logic              seen_q;
    logic              hit;

    // Limit reached by the edge-free run completed so far.
    always_comb hit = (idle_q >= idle_limit_i);

    // Edge-free run length, saturating, restarted by an edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idle_q <= '0;
        else if (rise_i)            idle_q <= '0;
        else if (idle_q != IDLE_MAX) idle_q <= idle_q + IDLE_W'(1);
    end

    // Sticky per-window record of a limit hit.
    always_ff @(posedge clk) begin
        if (!rst_n)         seen_q <= 1'b0;
        else if (win_end_i) seen_q <= 1'b0;
        else                seen_q <= seen_q | hit;
    end

    assign starved_o = seen_q | hit;

endmodule

// File: rtl/fm_limit_grader.sv
// Module fm_limit_grader
// Registers the window result: compares the count with the hard and soft
// windows, merges the activity verdict and forms the three-level grade.
// Holds every output between window closes. Reset grade is invalid.
module fm_limit_grader #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end_i,
    input  logic [CNT_W-1:0] win_count_i,
    input  logic             starved_i,
    input  logic             act_en_i,
    input  logic             freq_en_i,
    input  logic [CNT_W-1:0] hard_lo_i,
    input  logic [CNT_W-1:0] hard_hi_i,
    input  logic [CNT_W-1:0] soft_lo_i,
    input  logic [CNT_W-1:0] soft_hi_i,
    output logic [CNT_W-1:0] count_o,
    output logic             valid_o,
    output logic             act_lost_o,
    output logic             hard_fail_o,
    output logic             soft_alarm_o,
    output fm_pkg::grade_e   grade_o
);
    import fm_pkg::*;

    logic   hard_out, soft_out;
    logic   act_nx, hard_nx, soft_nx;
    grade_e grade_nx;

    // Range verdicts for the closing window.
    always_comb begin
        hard_out = outside_range(32'(win_count_i), 32'(hard_lo_i), 32'(hard_hi_i));
        soft_out = outside_range(32'(win_count_i), 32'(soft_lo_i), 32'(soft_hi_i));
    end

    // Next status with enables applied and invalid over flagged.
    always_comb begin
        act_nx  = act_en_i & starved_i;
        hard_nx = freq_en_i & hard_out;
        soft_nx = freq_en_i & soft_out & ~hard_out;
        if (act_nx || hard_nx) grade_nx = GRADE_INVALID;
        else if (soft_nx)      grade_nx = GRADE_FLAGGED;
        else                   grade_nx = GRADE_VALID;
    end

    // Result strobe and count, updated only when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            count_o <= '0;
        end else begin
            valid_o <= win_end_i;
            if (win_end_i) count_o <= win_count_i;
        end
    end

    // Status registers, updated only when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_lost_o   <= 1'b1;
            hard_fail_o  <= 1'b0;
            soft_alarm_o <= 1'b0;
            grade_o      <= GRADE_INVALID;
        end else if (win_end_i) begin
            act_lost_o   <= act_nx;
            hard_fail_o  <= hard_nx;
            soft_alarm_o <= soft_nx;
            grade_o      <= grade_nx;
        end
    end

endmodule

// File: rtl/freq_limit_monitor.sv
// Module freq_limit_monitor
// Top of the reference clock limit monitor: synchroniser, gate timer, idle
// watch and grader. Assumes ref_clk_i toggles at most once per system cycle
// and that the idle and gate widths cover the slowest monitored reference.
module freq_limit_monitor #(
    parameter int CNT_W       = 16,
    parameter int GATE_W      = 16,
    parameter int IDLE_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk_i,
    input  logic              cfg_act_en,
    input  logic              cfg_freq_en,
    input  logic [GATE_W-1:0] cfg_gate_len,
    input  logic [IDLE_W-1:0] cfg_idle_limit,
    input  logic [CNT_W-1:0]  cfg_hard_lo,
    input  logic [CNT_W-1:0]  cfg_hard_hi,
    input  logic [CNT_W-1:0]  cfg_soft_lo,
    input  logic [CNT_W-1:0]  cfg_soft_hi,
    output logic [CNT_W-1:0]  meas_count_o,
    output logic              meas_valid_o,
    output logic              act_lost_o,
    output logic              hard_fail_o,
    output logic              soft_alarm_o,
    output logic [1:0]        grade_o,
    output logic              ref_usable_o
);
    import fm_pkg::*;

    logic             rise;
    logic             win_end;
    logic [CNT_W-1:0] win_count;
    logic             starved;
    grade_e           grade;

    fm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ref_clk_i),
        .rise_o  (rise)
    );

    fm_gate_timer #(.GATE_W(GATE_W), .CNT_W(CNT_W)) gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .gate_len_i  (cfg_gate_len),
        .win_end_o   (win_end),
        .win_count_o (win_count)
    );

    fm_idle_watch #(.IDLE_W(IDLE_W)) idle_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_i       (rise),
        .win_end_i    (win_end),
        .idle_limit_i (cfg_idle_limit),
        .starved_o    (starved)
    );

    fm_limit_grader #(.CNT_W(CNT_W)) grade_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_end_i    (win_end),
        .win_count_i  (win_count),
        .starved_i    (starved),
        .act_en_i     (cfg_act_en),
        .freq_en_i    (cfg_freq_en),
        .hard_lo_i    (cfg_hard_lo),
        .hard_hi_i    (cfg_hard_hi),
        .soft_lo_i    (cfg_soft_lo),
        .soft_hi_i    (cfg_soft_hi),
        .count_o      (meas_count_o),
        .valid_o      (meas_valid_o),
        .act_lost_o   (act_lost_o),
        .hard_fail_o  (hard_fail_o),
        .soft_alarm_o (soft_alarm_o),
        .grade_o      (grade)
    );

    // Export the grade code and the usable flag derived from it.
    always_comb begin
        grade_o      = grade;
        ref_usable_o = (grade != GRADE_INVALID);
    end

endmodule

// File: rtl/fm_monitor_checker.sv
// Module fm_monitor_checker
// Temporal checks on the monitor's ports, bound to freq_limit_monitor.
module fm_monitor_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_act_en,
    input logic       cfg_freq_en,
    input logic       meas_valid_o,
    input logic       act_lost_o,
    input logic       hard_fail_o,
    input logic       soft_alarm_o,
    input logic [1:0] grade_o,
    input logic       ref_usable_o
);
    // Status holds between window results.
    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid_o |-> $stable({act_lost_o, hard_fail_o, soft_alarm_o, grade_o}));

    // A hard violation always yields an invalid, unusable grade.
    assert_hard_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hard_fail_o |-> (grade_o == 2'd2) && !ref_usable_o);

    // A soft alarm never coexists with a hard violation and leaves the input usable
    // unless activity was lost.
    assert_soft_usable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_alarm_o |-> !hard_fail_o && (act_lost_o || ref_usable_o));

    // Activity loss forces the invalid grade; code 3 never appears.
    assert_grade_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grade_o != 2'd3) && (act_lost_o -> grade_o == 2'd2));

    // Frequency checks disabled at the window close give no frequency status.
    assert_freq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid_o && !$past(cfg_freq_en) |-> !hard_fail_o && !soft_alarm_o);

    // Activity check disabled at the window close gives no activity loss.
    assert_act_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid_o && !$past(cfg_act_en) |-> !act_lost_o);

endmodule

bind freq_limit_monitor fm_monitor_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_act_en   (cfg_act_en),
    .cfg_freq_en  (cfg_freq_en),
    .meas_valid_o (meas_valid_o),
    .act_lost_o   (act_lost_o),
    .hard_fail_o  (hard_fail_o),
    .soft_alarm_o (soft_alarm_o),
    .grade_o      (grade_o),
    .ref_usable_o (ref_usable_o)
);

// File: tb/freq_limit_monitor_tb_top.sv
// Bench for freq_limit_monitor: a vector table walked by one loop, then
// directed tests for reset, window hold and recovery, and zero gate length.
module freq_limit_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_clk = 1'b0;
    logic        act_en = 1'b0, freq_en = 1'b0;
    logic [15:0] gate_len = 16'd64, idle_lim = 16'd40;
    logic [15:0] hard_lo = '0, hard_hi = '0, soft_lo = '0, soft_hi = '0;
    logic [15:0] count;
    logic        mvalid, act_lost, hard_fail, soft_alarm, usable;
    logic [1:0]  grade;

    int ref_period = 0;
    int ref_phase  = 0;
    int n_checks   = 0;
    int n_fails    = 0;
    bit finished   = 1'b0;

    always #10 clk = ~clk;

    freq_limit_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk),
        .cfg_act_en(act_en), .cfg_freq_en(freq_en),
        .cfg_gate_len(gate_len), .cfg_idle_limit(idle_lim),
        .cfg_hard_lo(hard_lo), .cfg_hard_hi(hard_hi),
        .cfg_soft_lo(soft_lo), .cfg_soft_hi(soft_hi),
        .meas_count_o(count), .meas_valid_o(mvalid), .act_lost_o(act_lost),
        .hard_fail_o(hard_fail), .soft_alarm_o(soft_alarm),
        .grade_o(grade), .ref_usable_o(usable)
    );

    // Reference generator: period in system cycles, 0 holds it low.
    always @(negedge clk) begin
        if (ref_period == 0) begin
            ref_clk   <= 1'b0;
            ref_phase = 0;
        end else if (ref_phase + 1 >= ref_period / 2) begin
            ref_clk   <= ~ref_clk;
            ref_phase = 0;
        end else begin
            ref_phase = ref_phase + 1;
        end
    end

    typedef struct packed {
        logic [7:0]  period;
        logic [15:0] gate, idle, hlo, hhi, slo, shi;
        logic        aen, fen;
        logic [15:0] exp_cnt;
        logic [1:0]  exp_grade;
        logic        exp_act, exp_hard, exp_soft;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd4,  16'd64, 16'd40, 16'd12, 16'd20, 16'd15, 16'd17, 1'b1, 1'b1, 16'd16, 2'd0, 1'b0, 1'b0, 1'b0},
        '{8'd8,  16'd64, 16'd40, 16'd12, 16'd20, 16'd15, 16'd17, 1'b1, 1'b1, 16'd8,  2'd2, 1'b0, 1'b1, 1'b0},
        '{8'd2,  16'd64, 16'd40, 16'd12, 16'd20, 16'd15, 16'd17, 1'b1, 1'b1, 16'd32, 2'd2, 1'b0, 1'b1, 1'b0},
        '{8'd4,  16'd64, 16'd40, 16'd12, 16'd20, 16'd17, 16'd19, 1'b1, 1'b1, 16'd16, 2'd1, 1'b0, 1'b0, 1'b1},
        '{8'd4,  16'd64, 16'd40, 16'd12, 16'd20, 16'd10, 16'd15, 1'b1, 1'b1, 16'd16, 2'd1, 1'b0, 1'b0, 1'b1},
        '{8'd4,  16'd64, 16'd40, 16'd16, 16'd16, 16'd16, 16'd16, 1'b1, 1'b1, 16'd16, 2'd0, 1'b0, 1'b0, 1'b0},
        '{8'd4,  16'd64, 16'd40, 16'd17, 16'd20, 16'd17, 16'd18, 1'b1, 1'b1, 16'd16, 2'd2, 1'b0, 1'b1, 1'b0},
        '{8'd8,  16'd64, 16'd40, 16'd12, 16'd20, 16'd15, 16'd17, 1'b1, 1'b0, 16'd8,  2'd0, 1'b0, 1'b0, 1'b0},
        '{8'd0,  16'd64, 16'd20, 16'd0,  16'd100,16'd0,  16'd100,1'b1, 1'b0, 16'd0,  2'd2, 1'b1, 1'b0, 1'b0},
        '{8'd0,  16'd64, 16'd20, 16'd12, 16'd20, 16'd15, 16'd17, 1'b0, 1'b0, 16'd0,  2'd0, 1'b0, 1'b0, 1'b0},
        '{8'd16, 16'd64, 16'd16, 16'd2,  16'd6,  16'd4,  16'd4,  1'b1, 1'b1, 16'd4,  2'd0, 1'b0, 1'b0, 1'b0},
        '{8'd16, 16'd64, 16'd15, 16'd2,  16'd6,  16'd4,  16'd4,  1'b1, 1'b1, 16'd4,  2'd2, 1'b1, 1'b0, 1'b0},
        '{8'd4,  16'd32, 16'd40, 16'd6,  16'd10, 16'd8,  16'd8,  1'b1, 1'b1, 16'd8,  2'd0, 1'b0, 1'b0, 1'b0},
        '{8'd0,  16'd64, 16'd20, 16'd12, 16'd20, 16'd15, 16'd17, 1'b1, 1'b1, 16'd0,  2'd2, 1'b1, 1'b1, 1'b0}
    };

    // Requirement each table row is aimed at.
    function automatic string row_tag(input int i);
        case (i)
            0, 12:     return "R1";
            1, 2:      return "R3";
            3, 4:      return "R4";
            5, 6:      return "R5";
            7, 9:      return "R7";
            8, 10, 11: return "R6";
            default:   return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_result();
        do @(negedge clk); while (!mvalid);
    endtask

    task automatic print_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    task automatic check_reset_state();
        check("R9", "grade", int'(grade), 2);
        check("R9", "act_lost", int'(act_lost), 1);
        check("R9", "usable", int'(usable), 0);
        check("R9", "hard", int'(hard_fail), 0);
        check("R9", "soft", int'(soft_alarm), 0);
        check("R9", "valid", int'(mvalid), 0);
        check("R9", "count", int'(count), 0);
    endtask

    initial begin
        #(150000 * 20);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            print_summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        // Table walk: apply, discard two windows, compare the third.
        for (int i = 0; i < NV; i++) begin
            ref_period = int'(VECS[i].period);
            gate_len   = VECS[i].gate;
            idle_lim   = VECS[i].idle;
            hard_lo    = VECS[i].hlo;
            hard_hi    = VECS[i].hhi;
            soft_lo    = VECS[i].slo;
            soft_hi    = VECS[i].shi;
            act_en     = VECS[i].aen;
            freq_en    = VECS[i].fen;
            repeat (3) wait_result();
            check("R1",  "count",    int'(count),      int'(VECS[i].exp_cnt));
            check(row_tag(i), "grade", int'(grade),    int'(VECS[i].exp_grade));
            check("R6",  "act_lost", int'(act_lost),   int'(VECS[i].exp_act));
            check("R3",  "hard",     int'(hard_fail),  int'(VECS[i].exp_hard));
            check("R4",  "soft",     int'(soft_alarm), int'(VECS[i].exp_soft));
            check("R10", "usable",   int'(usable),     int'(VECS[i].exp_grade != 2'd2));
        end

        // R8: good input, then stop it mid-run; status holds until window end.
        ref_period = 4; gate_len = 16'd64; idle_lim = 16'd20;
        hard_lo = 16'd12; hard_hi = 16'd20; soft_lo = 16'd15; soft_hi = 16'd17;
        act_en = 1'b1; freq_en = 1'b1;
        repeat (3) wait_result();
        check("R8", "grade before stop", int'(grade), 0);
        ref_period = 0;
        repeat (30) @(negedge clk);
        check("R8", "grade held mid-window", int'(grade), 0);
        check("R8", "act held mid-window", int'(act_lost), 0);
        wait_result();
        check("R6", "act_lost after stop", int'(act_lost), 1);
        ref_period = 4;
        wait_result();
        check("R8", "still invalid in disturbed window", int'(grade), 2);
        wait_result();
        check("R8", "cleared after one clean window", int'(grade), 0);
        check("R8", "usable after clean window", int'(usable), 1);

        // R2: zero gate length closes a window every cycle.
        gate_len = 16'd0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R2", "strobe every cycle", int'(mvalid), 1);
        end
        gate_len = 16'd64;
        @(negedge clk);

        // R9: reset in mid-run restores the reset state.
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        finished = 1'b1;
        print_summary();
        $finish;
    end

endmodule